// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Up-Counter

This block is a small binary up-counter. A single rising clock edge updates every bit of the count, so the bits never ripple. Two synchronous control inputs are active low. The clear input zeroes the count. The load input presets the count from a parallel data word. Both controls act at the next edge and override the count enables. When neither control is asserted, the counter advances by one only when both count enables are high. If either enable is low, it holds its value.

The two enables behave differently. The step enable `en_step` gates counting and nothing else. The chain enable `en_chain` gates counting and also gates the combinational terminal-count flag `tc_out`. That flag is high while the count is all ones and `en_chain` is high. Stages can therefore be chained into a wider synchronous counter. Each stage's `tc_out` drives the next stage's `en_chain`, and all stages share `en_step` and the clock. Decoding a chosen count and feeding it back, inverted, into the clear input shortens the count cycle.

Every edge selects exactly one of four modes: CLEAR, LOAD, STEP or HOLD. There is no other stored state. The mode is chosen by strict priority: CLEAR over LOAD, LOAD over STEP, STEP over HOLD. From any count, the next count is:
- 0 under CLEAR
- the data word under LOAD
- the count plus one under STEP
- the same value under HOLD

The count powers up unknown, so a clear must be applied first.

Top module: `sync_bin_counter`

## Requirements
- R1: A low `clr_n` at a rising edge sets `cnt` to 0, whatever the levels of `load_n`, `en_step` and `en_chain`.
- R2: With `clr_n` high, a low `load_n` at a rising edge copies `din` into `cnt`, whatever the levels of both enables.
- R3: When `clr_n` and `load_n` are both low at the same edge, the clear wins and `cnt` becomes 0.
- R4: With `clr_n` and `load_n` high, and `en_step` and `en_chain` both high, `cnt` increases by one at each rising edge.
- R5: With `clr_n` and `load_n` high, and either enable low, `cnt` keeps its value across the edge.
- R6: Counting from the all-ones value (15 at the default width of 4) wraps `cnt` to 0.
- R7: `tc_out` is high exactly when `cnt` is all ones and `en_chain` is high. `en_step` has no effect on it.
- R8: `tc_out` follows `en_chain` with no clock edge in between.
- R9: Changes on `clr_n`, `load_n`, `en_step`, `en_chain` or `din` between edges leave `cnt` unchanged until an edge samples them.
- R10: Feeding the inverted decode of count 9 into `clr_n` gives a repeating count of 0 to 9.
- R11: Two stages with the first stage's `tc_out` driving the second stage's `en_chain` form an 8-bit counter that counts 0 to 255 and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_step | input | 1 | Count enable that gates counting only |
| en_chain | input | 1 | Count enable that also gates `tc_out` |
| din | input | W (4) | Parallel preset data |
| cnt | output | W (4) | Registered count |
| tc_out | output | 1 | Terminal-count flag: count all ones and `en_chain` high |

## Verification
Clear and load can be requested in the same cycle. So can either control and a full count enable. The bench provokes clear plus load, and load plus both enables. It does this from states where each outcome gives a different result: a nonzero data word, and an all-ones count that would otherwise wrap. The bench judges the result by the count seen after the edge. In the 8-bit chain, the second stage's step and the first stage's wrap fall on the same edge; the bench checks each of these boundaries against the expected wide value.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_STEP  = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } sbc_mode_e;
endpackage

// File: rtl/sbc_mode_sel.sv
module sbc_mode_sel
    import sbc_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_step,
    input  logic      en_chain,
    output sbc_mode_e mode
);
    // Strict priority: clear, then load, then step, else hold.
    always_comb begin
        if (!clr_n)                    mode = MODE_CLEAR;
        else if (!load_n)              mode = MODE_LOAD;
        else if (en_step && en_chain)  mode = MODE_STEP;
        else                           mode = MODE_HOLD;
    end
endmodule

// File: rtl/sbc_count_reg.sv
module sbc_count_reg
    import sbc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  sbc_mode_e    mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_nxt;

    always_comb begin
        unique case (mode)
            MODE_CLEAR: cnt_nxt = '0;
            MODE_LOAD:  cnt_nxt = din;
            MODE_STEP:  cnt_nxt = cnt + ONE;
            MODE_HOLD:  cnt_nxt = cnt;
            default:    cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/sbc_carry.sv
module sbc_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic         en_chain,
    output logic         tc_out
);
    logic [W-1:0] all_ones;

    // Chain of AND stages so the decode repeats per bit.
    generate
        for (genvar i = 0; i < W; i++) begin : g_and
            if (i == 0) begin : g_first
                assign all_ones[i] = cnt[i];
            end else begin : g_next
                assign all_ones[i] = all_ones[i-1] & cnt[i];
            end
        end
    endgenerate

    assign tc_out = all_ones[W-1] & en_chain;
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
    import sbc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_step,
    input  logic         en_chain,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt,
    output logic         tc_out
);
    sbc_mode_e mode;

    sbc_mode_sel u_mode (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_step  (en_step),
        .en_chain (en_chain),
        .mode     (mode)
    );

    sbc_count_reg #(.W(W)) u_reg (
        .clk  (clk),
        .mode (mode),
        .din  (din),
        .cnt  (cnt)
    );

    sbc_carry #(.W(W)) u_carry (
        .cnt      (cnt),
        .en_chain (en_chain),
        .tc_out   (tc_out)
    );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic         en_step,
    input logic         en_chain,
    input logic [W-1:0] din,
    input logic [W-1:0] cnt,
    input logic         tc_out
);
    // Count is unknown until a clear has been taken; arm two edges later.
    logic arm1 = 1'b0;
    logic arm2 = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) arm1 <= 1'b1;
        arm2 <= arm1;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!arm2)
        !clr_n |=> (cnt == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!arm2)
        (clr_n && !load_n) |=> (cnt == $past(din)));

    p_step_r4: assert property (@(posedge clk) disable iff (!arm2)
        (clr_n && load_n && en_step && en_chain) |=> (cnt == $past(cnt) + W'(1)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!arm2)
        (clr_n && load_n && !(en_step && en_chain)) |=> $stable(cnt));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!arm2)
        (tc_out && en_step && clr_n && load_n) |=> (cnt == '0));

    p_tc_gate_r7: assert property (@(posedge clk) disable iff (!arm2)
        tc_out |-> en_chain);
endmodule

bind sync_bin_counter sbc_checker #(.W(W)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .en_step  (en_step),
    .en_chain (en_chain),
    .din      (din),
    .cnt      (cnt),
    .tc_out   (tc_out)
);

// File: tb/tb_sync_bin_counter.sv
module tb_chain2 (
    input  logic       clk,
    input  logic       clr_n,
    input  logic       en,
    output logic [7:0] wide,
    output logic       tc_hi
);
    logic tc_lo;
    sync_bin_counter #(.W(4)) u_lo (
        .clk(clk), .clr_n(clr_n), .load_n(1'b1), .en_step(en), .en_chain(en),
        .din(4'd0), .cnt(wide[3:0]), .tc_out(tc_lo));
    sync_bin_counter #(.W(4)) u_hi (
        .clk(clk), .clr_n(clr_n), .load_n(1'b1), .en_step(en), .en_chain(tc_lo),
        .din(4'd0), .cnt(wide[7:4]), .tc_out(tc_hi));
endmodule

module tb_sync_bin_counter;
    logic       clk = 1'b0;
    logic       clr_d = 1'b1, load_n = 1'b1, en_step = 1'b0, en_chain = 1'b0;
    logic       use_dec = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] cnt;
    logic       tc_out;
    logic       clr_n;
    logic       ch_clr_n = 1'b1, ch_en = 1'b0;
    logic [7:0] wide;
    logic       tc_hi;
    int         n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign clr_n = use_dec ? !(cnt == 4'd9) : clr_d;

    sync_bin_counter #(.W(4)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_step(en_step),
        .en_chain(en_chain), .din(din), .cnt(cnt), .tc_out(tc_out));

    tb_chain2 u_chain (.clk(clk), .clr_n(ch_clr_n), .en(ch_en), .wide(wide), .tc_hi(tc_hi));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic l, input logic ep, input logic ec, input logic [3:0] d);
        clr_d = c; load_n = l; en_step = ep; en_chain = ec; din = d;
    endtask

    task automatic t_clear();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd7); step();
        check("R1 clear with enables high", cnt, 0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd6); step();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd6); step();
        check("R1 clear with enables low", cnt, 0);
    endtask

    task automatic t_priority();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd9); step();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd5); step();
        check("R3 clear beats load", cnt, 0);
    endtask

    task automatic t_load();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd12); step();
        check("R2 load with enables low", cnt, 12);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd3); step();
        check("R2 load beats step", cnt, 3);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd15); step();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd10); step();
        check("R2 load from all-ones beats wrap", cnt, 10);
    endtask

    task automatic t_sequence();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0); step();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd12); step();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
        for (int i = 1; i <= 6; i++) begin
            step();
            check("R4 step value", cnt, (12 + i) % 16);
            check("R7 tc only at 15", tc_out, ((12 + i) % 16) == 15);
            if (i == 4) check("R6 wrap to 0", cnt, 0);
        end
        en_step = 1'b0; step(); step();
        check("R5 hold with step enable low", cnt, 2);
        en_step = 1'b1; en_chain = 1'b0; step();
        check("R5 hold with chain enable low", cnt, 2);
    endtask

    task automatic t_carry();
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'd15); step();
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0); #1;
        check("R7 tc high with step enable low", tc_out, 1);
        en_step = 1'b1; #0.5;
        check("R7 step enable does not touch tc", tc_out, 1);
        en_step = 1'b0; en_chain = 1'b0; #0.5;
        check("R8 tc drops with chain enable, no edge", tc_out, 0);
        en_chain = 1'b1; #0.5;
        check("R8 tc rises with chain enable, no edge", tc_out, 1);
        check("R8 count unchanged", cnt, 15);
    endtask

    task automatic t_between();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd7); step();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd7);
        @(posedge clk); #0.5;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd2); #1;
        check("R9 no change between edges", cnt, 7);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd2); @(negedge clk); step();
        check("R9 pulse not sampled leaves count", cnt, 7);
    endtask

    task automatic t_mod10();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd0); step();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
        use_dec = 1'b1;
        for (int i = 1; i <= 22; i++) begin
            step();
            check("R10 decode 9 gives 0..9", cnt, i % 10);
        end
        use_dec = 1'b0; clr_d = 1'b1;
    endtask

    task automatic t_chain();
        ch_clr_n = 1'b0; step();
        check("R11 chain cleared", wide, 0);
        ch_clr_n = 1'b1; ch_en = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            step();
            if (wide != 8'(i % 256) || i == 255 || i == 256 || i == 16) begin
                check("R11 chain value", wide, i % 256);
                check("R11 chain top tc", tc_hi, (i % 256) == 255);
            end else n_chk++;
        end
        ch_en = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_clear();
        t_priority();
        t_load();
        t_sequence();
        t_carry();
        t_between();
        t_mod10();
        t_chain();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule